// File: doc/BRIEF.md
# Serial-Programmed PLL Reference Control

This block holds the programming and reference-path logic of a frequency synthesizer. A three-wire serial port (serial clock, serial data, latch strobe) fills an 18-bit shift register one bit per rising serial clock, most-significant bit first. When the latch strobe rises, the lowest shifted bit acts as an address. With the address at 1, the next fourteen bits go into the reference control word. With the address at 0, the seventeen bits above the address go into a divider holding word, which is only stored and shown at the ports.

The reference control word sets a programmable reference divider and configures a digital model of the phase-detector output stage. That stage can be switched off (high impedance), run as a phase-frequency detector with either polarity, or put in a test mode that sends a raw counter output to the pump pin. The system clock acts as the reference oscillator. The serial pins are sampled on this clock, so the serial clock and the latch strobe must each stay at a level for at least two system clocks.

Top module: `pllref_ctl`

## Requirements
- R1: Each rising edge of ser_clk shifts ser_data into bit 0 of an 18-bit register and moves the older bits up by one, so the first bit sent ends in bit 17.
- R2: A rising ser_le with shift bit 0 = 1 loads ref_word with shift bits 14..1, one system clock after the strobe is sampled. div_word is left unchanged.
- R3: A rising ser_le with shift bit 0 = 0 loads div_word with shift bits 17..1. ref_word is left unchanged.
- R4: After a synchronous reset, ref_word = 14'h0402 (ratio 2, tri-state bit set, polarity 0, test 0), div_word = 0, ratio_err = 0, pump_oe = 0, and pump_up and pump_dn are 0.
- R5: ref_pulse is high for one clock per reference period. The period in clocks equals ref_word[9:0] for values 2 to 1023.
- R6: A reference ratio of 0 or 1 divides by 2 and sets ratio_err. ratio_err then stays high until reset, even after a legal ratio is loaded.
- R7: A newly loaded ratio takes effect only at the next reload, so the period already in progress completes with the old ratio.
- R8: With ref_word[13] = 0 and ref_word[10] = 1, pump_oe, pump_up and pump_dn are all 0.
- R9: With ref_word[13] = 0, ref_word[10] = 0 and ref_word[11] = 1, pump_oe = 1. A ref_pulse that arrives with no fb_pulse pending raises pump_up one clock later. A fb_pulse that arrives with no ref_pulse pending raises pump_dn one clock later. The pending output falls one clock after the opposite pulse arrives.
- R10: In the same running state with ref_word[11] = 0, the roles of pump_up and pump_dn are swapped.
- R11: With ref_word[13] = 1, pump_oe = 1 and pump_dn = 0. pump_up repeats ref_pulse one clock later when ref_word[11] = 0, and repeats fb_pulse one clock later when ref_word[11] = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, sampled on clk |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; its rising edge transfers the word |
| fb_pulse | input | 1 | One-clock pulse from the main divider |
| ref_word | output | 14 | Reference control word |
| div_word | output | 17 | Divider holding word |
| ratio_err | output | 1 | Sticky illegal-ratio flag |
| ref_pulse | output | 1 | Reference divider output pulse |
| pump_up | output | 1 | Up pump request, or the routed counter in test mode |
| pump_dn | output | 1 | Down pump request |
| pump_oe | output | 1 | Pump output enable; 0 stands for high impedance |

## Verification
The reference counter runs freely and cannot be paused. The hardest case to reach from the ports is a load that arrives inside a known reference period, together with detector states whose cause is known. The stimulus first waits until it sees a ref_pulse. It then uses long ratios (200 or 1000 clocks), so that a full serial load or an fb_pulse lands well inside the period. Each detector sequence starts by clearing any request that is already pending, so every later pump edge has a single known cause.

// File: rtl/pllref_pkg.sv
package pllref_pkg;

  typedef enum logic [1:0] {
    PD_OFF  = 2'd0,
    PD_RUN  = 2'd1,
    PD_TEST = 2'd2
  } pd_mode_e;

  // ratios below two are not allowed; they fall back to the smallest legal one
  function automatic logic ratio_illegal(input int unsigned r);
    return r < 2;
  endfunction

  function automatic int unsigned eff_ratio(input int unsigned r);
    return ratio_illegal(r) ? 2 : r;
  endfunction

  // test mode takes priority over the tri-state control
  function automatic pd_mode_e decode_mode(input logic tri_s, input logic test);
    if (test)       return PD_TEST;
    else if (tri_s) return PD_OFF;
    else            return PD_RUN;
  endfunction

endpackage

// File: rtl/refctl_shift.sv
module refctl_shift #(
  parameter int SHIFT_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic [SHIFT_W-1:0] word,
  output logic               latch_pulse
);
  logic               sclk_q;
  logic               le_q;
  logic               sclk_rise;
  logic [SHIFT_W-1:0] shreg;

  assign sclk_rise   = ser_clk & ~sclk_q;
  assign latch_pulse = ser_le & ~le_q;
  assign word        = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
      shreg  <= '0;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_le;
      if (sclk_rise) shreg <= {shreg[SHIFT_W-2:0], ser_data};
    end
  end

  // R1: new bit enters at the bottom
  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> (shreg[0] == $past(ser_data)));

  // R1: older bits move up by one
  a_r1_shift_up: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> (shreg[SHIFT_W-1:1] == $past(shreg[SHIFT_W-2:0])));

endmodule

// File: rtl/refctl_regs.sv
module refctl_regs
  import pllref_pkg::*;
#(
  parameter int SHIFT_W = 18,
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               latch_pulse,
  input  logic [SHIFT_W-1:0] word,
  output logic [RATIO_W+3:0] ref_word,
  output logic [SHIFT_W-2:0] div_word,
  output logic               ratio_err,
  output logic [RATIO_W-1:0] ratio_eff
);
  localparam int REF_W   = RATIO_W + 4;
  localparam int TRI_BIT = RATIO_W;
  localparam logic [REF_W-1:0] RST_REF = REF_W'(2) | (REF_W'(1) << TRI_BIT);

  logic             ld_ref;
  logic             ld_div;
  logic [REF_W-1:0] ref_next;

  assign ld_ref   = latch_pulse &  word[0];
  assign ld_div   = latch_pulse & ~word[0];
  assign ref_next = word[REF_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_word  <= RST_REF;
      div_word  <= '0;
      ratio_err <= 1'b0;
    end else begin
      if (ld_ref) begin
        ref_word <= ref_next;
        if (ratio_illegal(32'(ref_next[RATIO_W-1:0]))) ratio_err <= 1'b1;
      end
      if (ld_div) div_word <= word[SHIFT_W-1:1];
    end
  end

  assign ratio_eff = RATIO_W'(eff_ratio(32'(ref_word[RATIO_W-1:0])));

  // R3: a divider load leaves the reference word alone
  a_r3_ref_hold: assert property (@(posedge clk) disable iff (rst)
    ld_div |=> $stable(ref_word));

  // R2: a reference load leaves the divider word alone
  a_r2_div_hold: assert property (@(posedge clk) disable iff (rst)
    ld_ref |=> $stable(div_word));

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ratio_err |=> ratio_err);

  // R6: the counter never sees a ratio below two
  a_r6_ratio_floor: assert property (@(posedge clk) disable iff (rst)
    ratio_eff >= RATIO_W'(2));

endmodule

// File: rtl/refctl_refdiv.sv
module refctl_refdiv #(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ref_pulse
);
  logic [RATIO_W-1:0] cnt;
  logic               term;

  assign term = (cnt == '0);

  // the ratio is only sampled at terminal count
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= RATIO_W'(1);
      ref_pulse <= 1'b0;
    end else if (term) begin
      cnt       <= ratio - 1'b1;
      ref_pulse <= 1'b1;
    end else begin
      cnt       <= cnt - 1'b1;
      ref_pulse <= 1'b0;
    end
  end

  // R5: the output pulse lasts one clock
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R7: right after a reload the count starts from the ratio sampled then
  a_r7_reload_value: assert property (@(posedge clk) disable iff (rst)
    term |=> (cnt == $past(ratio) - 1'b1));

endmodule

// File: rtl/refctl_pd.sv
module refctl_pd
  import pllref_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic tri_s,
  input  logic pol,
  input  logic test,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_oe
);
  pd_mode_e mode;
  logic     up_q;
  logic     dn_q;
  logic     tst_q;
  logic     up_n;
  logic     dn_n;

  assign mode = decode_mode(tri_s, test);
  assign up_n = up_q | ref_pulse;
  assign dn_n = dn_q | fb_pulse;

  always_ff @(posedge clk) begin
    if (rst || mode != PD_RUN) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_n && dn_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_n;
      dn_q <= dn_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tst_q <= 1'b0;
    else     tst_q <= pol ? fb_pulse : ref_pulse;
  end

  always_comb begin
    pump_up = 1'b0;
    pump_dn = 1'b0;
    pump_oe = 1'b0;
    case (mode)
      PD_RUN: begin
        pump_oe = 1'b1;
        pump_up = pol ? up_q : dn_q;
        pump_dn = pol ? dn_q : up_q;
      end
      PD_TEST: begin
        pump_oe = 1'b1;
        pump_up = tst_q;
      end
      default: ;
    endcase
  end

  // R9: the detector never holds both requests
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(up_q && dn_q));

  // R9: a pending up request is cleared by the feedback pulse
  a_r9_up_clears: assert property (@(posedge clk) disable iff (rst)
    (up_q && fb_pulse) |=> !up_q);

  // R8: a disabled output drives no request
  a_r8_tri_quiet: assert property (@(posedge clk) disable iff (rst)
    !pump_oe |-> (!pump_up && !pump_dn));

  // R11: test mode drives only the up pin
  a_r11_test_dn_low: assert property (@(posedge clk) disable iff (rst)
    (mode == PD_TEST) |-> (!pump_dn && pump_oe));

endmodule

// File: rtl/pllref_ctl.sv
module pllref_ctl
  import pllref_pkg::*;
#(
  parameter int SHIFT_W = 18,
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  input  logic               fb_pulse,
  output logic [RATIO_W+3:0] ref_word,
  output logic [SHIFT_W-2:0] div_word,
  output logic               ratio_err,
  output logic               ref_pulse,
  output logic               pump_up,
  output logic               pump_dn,
  output logic               pump_oe
);
  localparam int TRI_BIT  = RATIO_W;
  localparam int POL_BIT  = RATIO_W + 1;
  localparam int TEST_BIT = RATIO_W + 3;

  logic [SHIFT_W-1:0] word;
  logic               latch_pulse;
  logic [RATIO_W-1:0] ratio_eff;

  refctl_shift #(.SHIFT_W(SHIFT_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .ser_le      (ser_le),
    .word        (word),
    .latch_pulse (latch_pulse)
  );

  refctl_regs #(.SHIFT_W(SHIFT_W), .RATIO_W(RATIO_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .latch_pulse (latch_pulse),
    .word        (word),
    .ref_word    (ref_word),
    .div_word    (div_word),
    .ratio_err   (ratio_err),
    .ratio_eff   (ratio_eff)
  );

  refctl_refdiv #(.RATIO_W(RATIO_W)) u_refdiv (
    .clk       (clk),
    .rst       (rst),
    .ratio     (ratio_eff),
    .ref_pulse (ref_pulse)
  );

  refctl_pd u_pd (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .tri_s     (ref_word[TRI_BIT]),
    .pol       (ref_word[POL_BIT]),
    .test      (ref_word[TEST_BIT]),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .pump_oe   (pump_oe)
  );

endmodule

// File: tb/pllref_ctl_tb.sv
module pllref_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_le = 1'b0;
  logic        fb_pulse = 1'b0;
  logic [13:0] ref_word;
  logic [16:0] div_word;
  logic        ratio_err;
  logic        ref_pulse;
  logic        pump_up;
  logic        pump_dn;
  logic        pump_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pllref_ctl u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .fb_pulse(fb_pulse), .ref_word(ref_word), .div_word(div_word), .ratio_err(ratio_err),
    .ref_pulse(ref_pulse), .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe)
  );

  function automatic int exp_period(input int r);
    return (r > 1) ? r : 2;
  endfunction

  function automatic logic [13:0] ref_fields(input int r, input bit tri_s, input bit pol, input bit test);
    return {test, 1'b0, pol, tri_s, r[9:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) begin
      ser_data = w[i];
      @(negedge clk); @(negedge clk);
      ser_clk = 1'b1;
      @(negedge clk); @(negedge clk);
      ser_clk = 1'b0;
    end
    @(negedge clk); @(negedge clk);
    ser_le = 1'b1;
    @(negedge clk); @(negedge clk);
    ser_le = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_ref(input int r, input bit tri_s, input bit pol, input bit test);
    send_word({3'b000, ref_fields(r, tri_s, pol, test), 1'b1});
  endtask

  task automatic wait_ref(output int t);
    do @(negedge clk); while (!ref_pulse);
    t = cyc;
  endtask

  task automatic pulse_fb;
    fb_pulse = 1'b1;
    @(negedge clk);
    fb_pulse = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int t0, t1, t2;
    logic [13:0] ref_snap;
    logic [16:0] dv;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R4 reset state
    chk(ref_word == 14'h0402, "R4 ref_word", ref_word, 14'h0402);
    chk(div_word == 0, "R4 div_word", div_word, 0);
    chk(ratio_err == 0, "R4 ratio_err", ratio_err, 0);
    chk({pump_oe, pump_up, pump_dn} == 3'b000, "R4 pump pins", {pump_oe, pump_up, pump_dn}, 0);
    wait_ref(t0); wait_ref(t1);
    chk(t1 - t0 == 2, "R5 reset period", t1 - t0, 2);

    // R2, R3, R1: reference and divider words with random content
    for (int k = 0; k < 6; k++) begin
      int r;
      r = 2 + int'($urandom_range(1021));
      load_ref(r, 1'b1, 1'b0, 1'b0);
      chk(ref_word == ref_fields(r, 1, 0, 0), "R2 ref load", ref_word, ref_fields(r, 1, 0, 0));
      ref_snap = ref_word;
      dv = 17'($urandom);
      send_word({dv, 1'b0});
      chk(div_word == dv, "R3 R1 div load msb first", div_word, dv);
      chk(ref_word == ref_snap, "R3 ref unchanged", ref_word, ref_snap);
      load_ref(r ^ 1, 1'b1, 1'b0, 1'b0);
      chk(div_word == dv, "R2 div unchanged", div_word, dv);
    end

    // R5, R8 random ratios with random tri-state setting
    for (int k = 0; k < 12; k++) begin
      int r;
      bit tb, pb;
      r = 2 + int'($urandom_range(38));
      tb = 1'($urandom);
      pb = 1'($urandom);
      load_ref(r, tb, pb, 1'b0);
      chk(pump_oe == !tb, "R8 output enable", pump_oe, !tb);
      if (tb) chk({pump_up, pump_dn} == 2'b00, "R8 pumps quiet", {pump_up, pump_dn}, 0);
      wait_ref(t0); wait_ref(t1); wait_ref(t2);
      chk(t1 - t0 == exp_period(r), "R5 period first", t1 - t0, exp_period(r));
      chk(t2 - t1 == exp_period(r), "R5 period second", t2 - t1, exp_period(r));
    end

    // R5 upper bound
    load_ref(1023, 1'b1, 1'b0, 1'b0);
    wait_ref(t0); wait_ref(t1);
    chk(t1 - t0 == 1023, "R5 max period", t1 - t0, 1023);

    // R7 change takes effect at the next reload
    load_ref(200, 1'b1, 1'b0, 1'b0);
    wait_ref(t0);
    load_ref(3, 1'b1, 1'b0, 1'b0);
    wait_ref(t1); wait_ref(t2);
    chk(t1 - t0 == 200, "R7 old ratio completes", t1 - t0, 200);
    chk(t2 - t1 == 3, "R7 new ratio after reload", t2 - t1, 3);

    // R6 illegal ratios
    chk(ratio_err == 0, "R6 no error yet", ratio_err, 0);
    load_ref(0, 1'b1, 1'b0, 1'b0);
    chk(ratio_err == 1, "R6 error on zero", ratio_err, 1);
    wait_ref(t0); wait_ref(t1); wait_ref(t2);
    chk(t2 - t1 == 2, "R6 zero clamps", t2 - t1, 2);
    load_ref(1, 1'b1, 1'b0, 1'b0);
    wait_ref(t0); wait_ref(t1); wait_ref(t2);
    chk(t2 - t1 == 2, "R6 one clamps", t2 - t1, 2);
    load_ref(9, 1'b1, 1'b0, 1'b0);
    chk(ratio_err == 1, "R6 sticky after legal", ratio_err, 1);
    wait_ref(t0); wait_ref(t1); wait_ref(t2);
    chk(t2 - t1 == 9, "R6 legal ratio after error", t2 - t1, 9);

    // R9 positive polarity detector
    load_ref(1000, 1'b0, 1'b1, 1'b0);
    chk(pump_oe == 1, "R9 enabled", pump_oe, 1);
    wait_ref(t0);
    @(negedge clk);
    chk(pump_up == 1, "R9 up after ref", pump_up, 1);
    pulse_fb;
    chk({pump_up, pump_dn} == 2'b00, "R9 cleared by fb", {pump_up, pump_dn}, 0);
    pulse_fb;
    chk({pump_up, pump_dn} == 2'b01, "R9 dn after fb", {pump_up, pump_dn}, 1);
    wait_ref(t1);
    chk(pump_dn == 1, "R9 dn held until ref", pump_dn, 1);
    @(negedge clk);
    chk({pump_up, pump_dn} == 2'b00, "R9 dn cleared by ref", {pump_up, pump_dn}, 0);

    // R10 negative polarity swaps the pins
    load_ref(1000, 1'b0, 1'b0, 1'b0);
    wait_ref(t0);
    @(negedge clk);
    chk({pump_up, pump_dn} == 2'b01, "R10 ref gives dn", {pump_up, pump_dn}, 1);
    pulse_fb;
    chk({pump_up, pump_dn} == 2'b00, "R10 cleared", {pump_up, pump_dn}, 0);
    pulse_fb;
    chk({pump_up, pump_dn} == 2'b10, "R10 fb gives up", {pump_up, pump_dn}, 2);

    // R11 test mode routing
    load_ref(1000, 1'b1, 1'b0, 1'b0);
    load_ref(1000, 1'b1, 1'b0, 1'b1);
    wait_ref(t0);
    @(negedge clk);
    chk({pump_oe, pump_up, pump_dn} == 3'b110, "R11 ref routed", {pump_oe, pump_up, pump_dn}, 6);
    @(negedge clk);
    chk(pump_up == 0, "R11 ref route one clock", pump_up, 0);
    pulse_fb;
    chk(pump_up == 0, "R11 fb not routed when pol low", pump_up, 0);
    load_ref(1000, 1'b1, 1'b1, 1'b1);
    pulse_fb;
    chk({pump_oe, pump_up, pump_dn} == 3'b110, "R11 fb routed", {pump_oe, pump_up, pump_dn}, 6);
    @(negedge clk);
    chk(pump_up == 0, "R11 fb route one clock", pump_up, 0);

    // R4 reset again restores the state
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ref_word == 14'h0402, "R4 ref after reset", ref_word, 14'h0402);
    chk(ratio_err == 0, "R4 error cleared", ratio_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule